// File: doc/BRIEF.md
# Confirmed-Stride Block Prefetcher

This block watches the demand stream of one cache: at most one cache-block address per cycle, qualified by a valid bit. It keeps the two newest accepted addresses and, together with the address arriving now, forms a window of three accesses. When the step from the oldest to the middle address equals the step from the middle to the newest, and that step is not zero, the block asks for the block one stride past the newest access. A single step is never enough: the stride must repeat before the block acts. There is one history for the whole stream.

The request appears on a valid/ready output one cycle after the demand that caused it. The request stays up until the consumer takes it. If a fresh trigger arrives while a request is still waiting, the fresh request takes its place. The block works on signed differences that are wider than an address, so falling strides are handled. A target that would fall below address zero or past the top of the address space is dropped, so the address never wraps around.

Top module: `stride_prefetcher`

## Requirements
- R1: A synchronous active-high `rst` clears the history, the fill count and the pending request: `pf_valid` is 0 in the cycle after reset.
- R2: After reset, the first two accepted demands never produce a prefetch. The third accepted demand is the first that can.
- R3: With accepted demands X1, X2, X3 in order, where X2−X1 = X3−X2 = S and S ≠ 0, the block raises `pf_valid` with `pf_addr` = X3+S one cycle after X3 is accepted.
- R4: A window whose two differences are unequal produces no prefetch. One example is an index that is multiplied rather than incremented (1, 4, 16, 64, 256).
- R5: A window with stride zero (the same block repeated) produces no prefetch.
- R6: Falling strides are detected and applied (for example 1000, 990, 980 gives 970).
- R7: When X3+S, taken as an exact signed integer, is below 0 or at or above 2^ADDR_W, no prefetch is produced.
- R8: While `pf_valid` is 1 and `pf_ready` is 0, and no new trigger occurs, `pf_valid` stays 1 and `pf_addr` keeps its value.
- R9: A new trigger while a request is pending and not accepted replaces `pf_addr` with the new target.
- R10: A cycle with `dmd_valid` low leaves the history unchanged, whatever `dmd_addr` carries.
- R11: A request is accepted in a cycle where `pf_valid` and `pf_ready` are both 1. If no new trigger occurs in that cycle, `pf_valid` is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| dmd_valid | input | 1 | Demand access present this cycle |
| dmd_addr | input | ADDR_W | Demand cache-block address |
| pf_valid | output | 1 | Prefetch request pending |
| pf_addr | output | ADDR_W | Prefetch cache-block address |
| pf_ready | input | 1 | Consumer takes the pending request this cycle |

## Verification
The properties assume that `dmd_valid`, `dmd_addr` and `pf_ready` are driven to known values in every cycle after reset. They also assume that the consumer may hold `pf_ready` low for any number of cycles. The bench changes the inputs only on the falling clock edge, and it keeps them known through idle cycles. The random stimulus is built from strided runs of random length and random signed stride. These runs are mixed with jumps, repeats and idle cycles, while `pf_ready` is pulled low about a quarter of the time. This exercises both the hold rule and the replace rule without breaking the input assumptions.

// File: rtl/stride_pf_pkg.sv
package stride_pf_pkg;
  // Widest address the arithmetic helpers support.
  localparam int unsigned SP_MAX_AW = 64;
  // Exact signed width: one bit for the sign, one for the sum carry.
  localparam int unsigned SP_SW = SP_MAX_AW + 2;

  typedef logic [SP_MAX_AW-1:0] sp_addr_t;
  typedef logic signed [SP_SW-1:0] sp_wide_t;

  // Exact signed difference a - b.
  function automatic sp_wide_t sp_diff(input sp_addr_t a, input sp_addr_t b);
    sp_wide_t wa, wb;
    wa = sp_wide_t'({2'b00, a});
    wb = sp_wide_t'({2'b00, b});
    return wa - wb;
  endfunction

  // Exact signed sum base + step.
  function automatic sp_wide_t sp_step(input sp_addr_t base, input sp_wide_t step);
    sp_wide_t wb;
    wb = sp_wide_t'({2'b00, base});
    return wb + step;
  endfunction

  // True when t is a legal unsigned address of aw bits.
  function automatic logic sp_fits(input sp_wide_t t, input int unsigned aw);
    logic [SP_SW-1:0] u;
    u = t;
    return (u >> aw) == '0;
  endfunction
endpackage

// File: rtl/sp_history.sv
module sp_history #(
  parameter int unsigned AW    = 32,
  parameter int unsigned DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [AW-1:0] addr,
  output logic [AW-1:0] slot [DEPTH],
  output logic [$clog2(DEPTH+1)-1:0] fill
);
  localparam int unsigned FW = $clog2(DEPTH + 1);
  localparam logic [FW-1:0] FULL = FW'(DEPTH);

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk) begin
        if (rst) begin
          slot[g] <= '0;
        end else if (push) begin
          if (g == 0) slot[g] <= addr;
          else        slot[g] <= slot[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      fill <= '0;
    end else if (push && fill != FULL) begin
      fill <= fill + FW'(1);
    end
  end
endmodule

// File: rtl/sp_detect.sv
module sp_detect
  import stride_pf_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          valid,
  input  logic [AW-1:0] newest,
  input  logic [AW-1:0] mid,
  input  logic [AW-1:0] oldest,
  input  logic          primed,
  output logic          fire,
  output logic [AW-1:0] target
);
  sp_wide_t d_old, d_new, tgt_w;
  logic     same, nonzero, fits;

  always_comb begin
    d_old   = sp_diff(sp_addr_t'(mid), sp_addr_t'(oldest));
    d_new   = sp_diff(sp_addr_t'(newest), sp_addr_t'(mid));
    tgt_w   = sp_step(sp_addr_t'(newest), d_new);
    same    = (d_old == d_new);
    nonzero = (d_new != '0);
    fits    = sp_fits(tgt_w, AW);
    fire    = valid && primed && same && nonzero && fits;
    target  = tgt_w[AW-1:0];
  end
endmodule

// File: rtl/sp_issue.sv
module sp_issue #(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic          ready,
  output logic          valid,
  output logic [AW-1:0] addr
);
  logic taken;
  assign taken = valid && ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      addr  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      addr  <= load_addr;
    end else if (taken) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/stride_prefetcher.sv
module stride_prefetcher #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dmd_valid,
  input  logic [ADDR_W-1:0] dmd_addr,
  output logic              pf_valid,
  output logic [ADDR_W-1:0] pf_addr,
  input  logic              pf_ready
);
  // Two stored entries plus the incoming demand form the three-access window.
  localparam int unsigned KEEP = 2;
  localparam int unsigned FW   = $clog2(KEEP + 1);

  logic [ADDR_W-1:0] hist [KEEP];
  logic [FW-1:0]     fill;
  logic [ADDR_W-1:0] newest_kept;
  logic              primed;
  logic              fire;
  logic [ADDR_W-1:0] fire_addr;

  sp_history #(.AW(ADDR_W), .DEPTH(KEEP)) u_hist (
    .clk  (clk),
    .rst  (rst),
    .push (dmd_valid),
    .addr (dmd_addr),
    .slot (hist),
    .fill (fill)
  );

  assign newest_kept = hist[0];
  assign primed      = (fill == FW'(KEEP));

  sp_detect #(.AW(ADDR_W)) u_det (
    .valid  (dmd_valid),
    .newest (dmd_addr),
    .mid    (hist[0]),
    .oldest (hist[1]),
    .primed (primed),
    .fire   (fire),
    .target (fire_addr)
  );

  sp_issue #(.AW(ADDR_W)) u_iss (
    .clk       (clk),
    .rst       (rst),
    .load      (fire),
    .load_addr (fire_addr),
    .ready     (pf_ready),
    .valid     (pf_valid),
    .addr      (pf_addr)
  );
endmodule

// File: rtl/stride_prefetcher_chk.sv
module stride_prefetcher_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned FW     = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              dmd_valid,
  input logic [ADDR_W-1:0] dmd_addr,
  input logic              pf_valid,
  input logic [ADDR_W-1:0] pf_addr,
  input logic              pf_ready,
  input logic              fire,
  input logic [ADDR_W-1:0] newest_kept,
  input logic [FW-1:0]     fill
);
  // R1
  reset_clears_chk: assert property (@(posedge clk) rst |=> !pf_valid);

  // R2
  untrained_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (fill < FW'(2)) |-> !fire);

  // R3
  fire_issues_chk: assert property (@(posedge clk) disable iff (rst)
    fire |=> pf_valid);

  // R5
  zero_stride_chk: assert property (@(posedge clk) disable iff (rst)
    fire |-> (dmd_addr != newest_kept));

  // R8
  hold_pending_chk: assert property (@(posedge clk) disable iff (rst)
    (pf_valid && !pf_ready && !fire) |=> (pf_valid && $stable(pf_addr)));

  // R10
  idle_keeps_hist_chk: assert property (@(posedge clk) disable iff (rst)
    !dmd_valid |=> ($stable(newest_kept) && $stable(fill)));

  // R11
  accept_drops_chk: assert property (@(posedge clk) disable iff (rst)
    (pf_valid && pf_ready && !fire) |=> !pf_valid);
endmodule

bind stride_prefetcher stride_prefetcher_chk #(.ADDR_W(ADDR_W), .FW(FW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .dmd_valid   (dmd_valid),
  .dmd_addr    (dmd_addr),
  .pf_valid    (pf_valid),
  .pf_addr     (pf_addr),
  .pf_ready    (pf_ready),
  .fire        (fire),
  .newest_kept (newest_kept),
  .fill        (fill)
);

// File: tb/stride_prefetcher_bench.sv
module stride_prefetcher_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        dmd_valid = 1'b0;
  logic [31:0] dmd_addr = '0;
  logic        pf_valid;
  logic [31:0] pf_addr;
  logic        pf_ready = 1'b1;

  int checks = 0;
  int errors = 0;

  // Reference state kept by the bench.
  longint m_h0, m_h1;
  int     m_fill;
  bit     m_pv;
  longint m_pa;

  always #5 clk = ~clk;

  stride_prefetcher u_stride_prefetcher (
    .clk(clk), .rst(rst), .dmd_valid(dmd_valid), .dmd_addr(dmd_addr),
    .pf_valid(pf_valid), .pf_addr(pf_addr), .pf_ready(pf_ready)
  );

  // Expected trigger for a window (a, b, c), oldest first.
  function automatic bit exp_fire(longint a, longint b, longint c, int filled);
    longint s1, s2, t;
    s1 = b - a;
    s2 = c - b;
    t  = c + s2;
    return (filled >= 2) && (s1 == s2) && (s2 != 0) && (t >= 0) && (t < 64'sh1_0000_0000);
  endfunction

  task automatic check(input string tag);
    checks++;
    if (pf_valid !== m_pv || (m_pv && pf_addr !== 32'(m_pa))) begin
      errors++;
      $display("FAIL %s: valid=%0b addr=%h expected valid=%0b addr=%h",
               tag, pf_valid, pf_addr, m_pv, 32'(m_pa));
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; dmd_valid = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    m_fill = 0; m_h0 = 0; m_h1 = 0; m_pv = 0; m_pa = 0;
    check("R1 reset");
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic step(input bit v, input logic [31:0] a, input bit rdy, input string tag);
    bit     f, acc;
    longint na;
    @(negedge clk);
    dmd_valid = v; dmd_addr = a; pf_ready = rdy;
    na  = longint'({32'd0, a});
    f   = v && exp_fire(m_h1, m_h0, na, m_fill);
    acc = m_pv && rdy;
    @(posedge clk); #1;
    if (f) begin
      m_pv = 1; m_pa = na + (na - m_h0);
    end else if (acc) begin
      m_pv = 0;
    end
    if (v) begin
      m_h1 = m_h0; m_h0 = na;
      if (m_fill < 2) m_fill++;
    end
    check(tag);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4471));
    do_reset();

    // R2 / R3: rising stride, first two quiet, then prefetches
    step(1, 32'd100, 1, "R2 first");
    step(1, 32'd104, 1, "R2 second");
    step(1, 32'd108, 1, "R3 fire 112");
    step(1, 32'd112, 1, "R3 fire 116");

    // R1: reset mid-run empties history
    do_reset();
    step(1, 32'd116, 1, "R1 post-reset one");
    step(1, 32'd120, 1, "R1 post-reset two");

    // R5: repeated block
    do_reset();
    step(1, 32'd50, 1, "R5 rep"); step(1, 32'd50, 1, "R5 rep"); step(1, 32'd50, 1, "R5 rep");

    // R4: multiplied index
    for (int i = 0, k = 1; i < 5; i++, k *= 4) step(1, 32'(k), 1, "R4 multiplied");

    // R6: falling stride
    step(1, 32'd1000, 1, "R6"); step(1, 32'd990, 1, "R6"); step(1, 32'd980, 1, "R6 fire 970");

    // R7: overflow and underflow suppressed
    step(1, 32'hFFFF_FFE8, 1, "R7"); step(1, 32'hFFFF_FFF0, 1, "R7");
    step(1, 32'hFFFF_FFF8, 1, "R7 top overflow");
    step(1, 32'd20, 1, "R7"); step(1, 32'd10, 1, "R7"); step(1, 32'd0, 1, "R7 below zero");

    // R10: idle cycles with junk address keep history
    step(1, 32'd400, 1, "R10"); step(0, 32'hDEAD_BEEF, 1, "R10 idle");
    step(1, 32'd408, 1, "R10"); step(0, 32'h0000_0123, 1, "R10 idle");
    step(1, 32'd416, 1, "R10 fire 424");

    // R8 / R9 / R11: back-pressure, replacement, acceptance
    step(1, 32'd424, 0, "R8 new trigger 432");
    step(0, 32'd0, 0, "R8 hold");
    step(0, 32'd0, 0, "R8 hold");
    step(1, 32'd432, 0, "R9 replace 440");
    step(0, 32'd0, 1, "R11 accept");
    step(0, 32'd0, 1, "R11 dropped");

    // Random strided runs mixed with jumps, repeats and idles
    for (int r = 0; r < 300; r++) begin
      int     len  = 1 + int'($urandom_range(6));
      int     s    = int'($urandom_range(40)) - 20;
      longint base = longint'($urandom);
      if ($urandom_range(9) == 0) base = longint'($urandom_range(60));
      for (int j = 0; j < len; j++) begin
        bit v = ($urandom_range(7) != 0);
        bit rd = ($urandom_range(3) != 0);
        step(v, 32'(base), rd, "R3 random");
        if (v) base = base + s;
      end
      if ($urandom_range(19) == 0) do_reset();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule